// File: doc/BRIEF.md
# HDLC Frame Receiver

This block recovers HDLC frames from a synchronous serial line. One bit is taken on each clock cycle in which the bit strobe is high. How that strobe is made, from a local divider or a recovered line clock, is outside the block. The receiver finds the 0x7E flag pattern in the raw bit stream and removes the zero that follows every run of five ones. It packs the remaining bits into bytes and runs a CRC-CCITT check over the frame contents.

Payload bytes leave on a simple valid/last stream. The receiver holds data back so that the two check-sequence bytes never appear as payload. Each frame that carries data produces one status strobe with a 2-bit code: good, bad check sequence, aborted, or framing error. Flags with nothing between them produce nothing. Idle ones after a flag also produce nothing.

Top module: `hdlc_rx`

## Requirements
- R1: A frame opens and closes on the raw 8-bit pattern 0x7E (0, six 1s, 0 in line order), matched before any zero removal. Line bits seen before the first flag are ignored. A 0x7E byte inside the payload is delivered as data.
- R2: Between flags, a 0 received directly after five consecutive 1s is dropped. The run of 1s is counted across byte boundaries, so payloads of all 0xFF bytes come out intact.
- R3: Bits are packed least significant bit first: the first data bit after zero removal lands in `out_data[0]`.
- R4: The last 16 data bits before the closing flag are the check sequence and are never output. The final payload byte carries `out_last`, and `done_valid` is high in that same cycle.
- R5: The check uses x^16 + x^12 + x^5 + 1, bit-reflected, with the register preset to 0xFFFF at every flag or abort. The register runs over payload plus received check sequence. A residue of 0xF0B8 gives `done_code` 0 (good); any other residue gives 1 (bad check). The payload is delivered in both cases.
- R6: A seventh consecutive 1 inside a frame that holds data ahead of the run gives `done_code` 2 (abort) with no `out_last`. The receiver then ignores the line until the next flag. Runs of 1s that follow a flag directly report nothing.
- R7: Flags with no data between them yield no bytes and no status. A single flag may close one frame and open the next. Every reported frame gives exactly one single-cycle `done_valid`.
- R8: A frame whose data bit count is not a multiple of 8, or that has fewer than 2 payload bytes ahead of the check sequence, gives `done_code` 3 (framing) and no `out_last`.
- R9: `done_valid` goes high on the clock edge after the edge that samples the final bit of the closing flag (or the aborting 1).
- R10: While and after reset, with no bit strobe, `out_valid` and `done_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit strobe: sample `rx_bit` this cycle |
| rx_bit | input | 1 | Serial line data |
| out_valid | output | 1 | Payload byte present on `out_data` |
| out_data | output | 8 | Payload byte, first received bit in bit 0 |
| out_last | output | 1 | Final payload byte of a good or bad-check frame |
| done_valid | output | 1 | One-cycle end-of-frame status strobe |
| done_code | output | 2 | 0 good, 1 bad check, 2 abort, 3 framing |

## Verification
The bench sweeps payload lengths from the 2-byte minimum upwards under several byte patterns and bit-strobe gap spacings. An all-ones payload makes stuffing straddle byte boundaries, so a receiver that reset its ones count per byte would corrupt the data. Payloads containing 0x7E would cause false closes if flag matching ran after zero removal. Shared flags, repeated flags and idle ones after a flag would show up as spurious empty or aborted frames in a receiver that reported on every flag. The 1-byte and non-byte-aligned frames catch a receiver that leaks check-sequence bytes or marks a truncated frame as good. The done latency check catches an extra or missing register stage.

// File: rtl/hdlc_rx_pkg.sv
// Shared types and constants for the HDLC frame receiver.
package hdlc_rx_pkg;

    // End-of-frame status code presented with done_valid.
    typedef enum logic [1:0] {
        ST_GOOD    = 2'd0,
        ST_CRC_BAD = 2'd1,
        ST_ABORT   = 2'd2,
        ST_FRAMING = 2'd3
    } frame_status_e;

    localparam logic [7:0] FLAG_PATTERN = 8'h7E;

endpackage

// File: rtl/hdlc_rx_linebits.sv
// Line-level bit processor.
// Keeps an 8-bit window of raw line bits. Matches the flag pattern on the
// raw window, detects abort runs and tags stuffed zeros as they enter.
// A bit leaves the window as data only if it entered inside a frame and was
// not a stuffed zero, so flag bits never reach the byte packer.
// Assumes: one line bit per cycle with bit_en high; first-sent bit enters first.
module hdlc_rx_linebits #(
    parameter int         WIN_W     = 8,
    parameter logic [7:0] FLAG_PAT  = 8'h7E,
    parameter int         STUFF_RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    output logic data_take,
    output logic data_bit,
    output logic flag_evt,
    output logic abort_evt,
    output logic pre_run_vld
);
    localparam int RUN_MAX = STUFF_RUN + 2;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    logic [WIN_W-1:0] win_bit_q;
    logic [WIN_W-1:0] win_vld_q;
    logic [WIN_W-1:0] win_next;
    logic [RUN_W-1:0] ones_q;
    logic             in_frame_q;
    logic             stuffed;
    logic             abort_hit;

    // Decode the window as it will look after this bit enters.
    always_comb begin
        win_next    = {win_bit_q[WIN_W-2:0], rx_bit};
        stuffed     = !rx_bit && (ones_q == RUN_W'(STUFF_RUN));
        abort_hit   = bit_en && rx_bit && (ones_q == RUN_W'(STUFF_RUN + 1));
        flag_evt    = bit_en && (win_next == FLAG_PAT);
        abort_evt   = abort_hit && in_frame_q;
        data_take   = bit_en && win_vld_q[WIN_W-1];
        data_bit    = win_bit_q[WIN_W-1];
        pre_run_vld = win_vld_q[WIN_W-2];
    end

    // Shift the raw window, its data tags, the ones run and the frame state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_bit_q  <= '0;
            win_vld_q  <= '0;
            ones_q     <= '0;
            in_frame_q <= 1'b0;
        end else if (bit_en) begin
            win_bit_q <= win_next;
            if (flag_evt || abort_hit) begin
                win_vld_q <= '0;
            end else begin
                win_vld_q <= {win_vld_q[WIN_W-2:0], in_frame_q && !stuffed};
            end
            if (!rx_bit) begin
                ones_q <= '0;
            end else if (ones_q != RUN_W'(RUN_MAX)) begin
                ones_q <= ones_q + 1'b1;
            end
            if (flag_evt) begin
                in_frame_q <= 1'b1;
            end else if (abort_hit) begin
                in_frame_q <= 1'b0;
            end
        end
    end

    AST_HUNT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame_q |-> !data_take);                                  // R6
    AST_FLAG_BITS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        flag_evt |=> !data_take);                                     // R1

endmodule

// File: rtl/hdlc_rx_fcs.sv
// Bit-serial check-sequence register.
// Shifts one data bit per step, bit-reflected. The register is preset at
// every frame boundary. match reports whether the value after this cycle's
// step equals the good-frame residue.
module hdlc_rx_fcs #(
    parameter int            FCS_W    = 16,
    parameter logic [15:0]   POLY_REV = 16'h8408,
    parameter logic [15:0]   PRESET   = 16'hFFFF,
    parameter logic [15:0]   RESIDUE  = 16'hF0B8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic din,
    input  logic init,
    output logic match
);
    logic [FCS_W-1:0] crc_q;
    logic [FCS_W-1:0] crc_d;

    // Next register value and residue compare.
    always_comb begin
        crc_d = crc_q;
        if (step) begin
            crc_d = {1'b0, crc_q[FCS_W-1:1]} ^ ((crc_q[0] ^ din) ? POLY_REV : '0);
        end
        match = (crc_d == RESIDUE);
    end

    // Hold the register; preset it at frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            crc_q <= PRESET;
        end else begin
            crc_q <= crc_d;
        end
    end

    AST_PRESET_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init) |-> crc_q == PRESET);                             // R5

endmodule

// File: rtl/hdlc_rx_deframe.sv
// Byte packer, check-sequence holdback and end-of-frame reporting.
// Packs data bits LSB first and delays bytes by FCS_BYTES plus one pending
// byte. The last payload byte can then be marked when the closing flag
// arrives. End-of-frame results go through a one-cycle finish stage, so the
// final byte never competes with a normal byte emission.
// Assumes: data_take never coincides with the cycle after flag_evt/abort_evt.
module hdlc_rx_deframe
    import hdlc_rx_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int FCS_BYTES   = 2,
    parameter int MIN_PAYLOAD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_take,
    input  logic              data_bit,
    input  logic              flag_evt,
    input  logic              abort_evt,
    input  logic              pre_run_vld,
    input  logic              crc_match,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              done_valid,
    output frame_status_e     done_code
);
    localparam int BPOS_W = $clog2(BYTE_W);
    localparam int NEED   = MIN_PAYLOAD + FCS_BYTES;
    localparam int CNT_W  = $clog2(NEED + 1);
    localparam logic [BPOS_W-1:0] LAST_POS = BPOS_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] asm_q, asm_n;
    logic [BYTE_W-1:0] hold_q [FCS_BYTES];
    logic [FCS_BYTES-1:0] hold_v_q;
    logic [BYTE_W-1:0] pend_q, pend_n;
    logic              pend_v_q, pend_v_n;
    logic [BPOS_W-1:0] bpos_q, bpos_n;
    logic [CNT_W-1:0]  nbytes_q, nbytes_n;
    logic              any_q, any_n;
    logic              byte_done, closing, abort_rep;
    frame_status_e     close_code;
    logic              fin_q, fin_tail_q;
    frame_status_e     fin_code_q;
    logic [BYTE_W-1:0] fin_data_q;

    // Assemble the next byte and work out the end-of-frame verdict.
    always_comb begin
        asm_n     = {data_bit, asm_q[BYTE_W-1:1]};
        byte_done = data_take && (bpos_q == LAST_POS);
        bpos_n    = data_take ? bpos_q + 1'b1 : bpos_q;
        any_n     = any_q || data_take;
        nbytes_n  = (byte_done && nbytes_q != CNT_W'(NEED)) ? nbytes_q + 1'b1 : nbytes_q;
        pend_n    = byte_done ? hold_q[FCS_BYTES-1] : pend_q;
        pend_v_n  = byte_done ? hold_v_q[FCS_BYTES-1] : pend_v_q;
        closing   = flag_evt && any_n;
        abort_rep = abort_evt && (any_n || pre_run_vld);
        if (bpos_n != '0 || nbytes_n != CNT_W'(NEED)) begin
            close_code = ST_FRAMING;
        end else if (crc_match) begin
            close_code = ST_GOOD;
        end else begin
            close_code = ST_CRC_BAD;
        end
    end

    // Byte packing and holdback pipeline, cleared at every frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || flag_evt || abort_evt) begin
            asm_q    <= '0;
            bpos_q   <= '0;
            nbytes_q <= '0;
            any_q    <= 1'b0;
            hold_v_q <= '0;
            pend_v_q <= 1'b0;
            pend_q   <= '0;
            for (int i = 0; i < FCS_BYTES; i++) hold_q[i] <= '0;
        end else if (data_take) begin
            asm_q    <= asm_n;
            bpos_q   <= bpos_n;
            any_q    <= 1'b1;
            nbytes_q <= nbytes_n;
            if (byte_done) begin
                pend_q   <= pend_n;
                pend_v_q <= pend_v_n;
                hold_q[0] <= asm_n;
                for (int i = 1; i < FCS_BYTES; i++) hold_q[i] <= hold_q[i-1];
                hold_v_q <= {hold_v_q[FCS_BYTES-2:0], 1'b1};
            end
        end
    end

    // Finish stage: capture the verdict, then present status and final byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q      <= 1'b0;
            fin_tail_q <= 1'b0;
            fin_code_q <= ST_GOOD;
            fin_data_q <= '0;
        end else if (closing || abort_rep) begin
            fin_q      <= 1'b1;
            fin_code_q <= abort_rep ? ST_ABORT : close_code;
            fin_tail_q <= closing && (close_code != ST_FRAMING) && pend_v_n;
            fin_data_q <= pend_n;
        end else begin
            fin_q <= 1'b0;
        end
    end

    // Output register: normal byte emission or the finish-stage result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_last   <= 1'b0;
            done_valid <= 1'b0;
            done_code  <= ST_GOOD;
        end else begin
            out_valid  <= 1'b0;
            out_last   <= 1'b0;
            done_valid <= 1'b0;
            if (byte_done && pend_v_q) begin
                out_valid <= 1'b1;
                out_data  <= pend_q;
            end
            if (fin_q) begin
                done_valid <= 1'b1;
                done_code  <= fin_code_q;
                if (fin_tail_q) begin
                    out_valid <= 1'b1;
                    out_last  <= 1'b1;
                    out_data  <= fin_data_q;
                end
            end
        end
    end

    AST_EMIT_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> $past(data_take));               // R9
    AST_FIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> !data_take);                                        // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);                                  // R7
    AST_LAST_NOT_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> done_valid && done_code != ST_FRAMING && done_code != ST_ABORT); // R8

endmodule

// File: rtl/hdlc_rx.sv
// HDLC frame receiver top.
// Chains the line-bit processor, the check-sequence register and the
// deframer. Assumes rx_bit is already synchronous to clk and that bit_en
// marks each line bit for exactly one cycle.
module hdlc_rx
    import hdlc_rx_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int FCS_BYTES   = 2,
    parameter int MIN_PAYLOAD = 2,
    parameter int STUFF_RUN   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              done_valid,
    output logic [1:0]        done_code
);
    localparam int FCS_W = FCS_BYTES * BYTE_W;

    logic          data_take, data_bit, flag_evt, abort_evt, pre_run_vld;
    logic          crc_match;
    frame_status_e status;

    hdlc_rx_linebits #(
        .WIN_W     (8),
        .FLAG_PAT  (FLAG_PATTERN),
        .STUFF_RUN (STUFF_RUN)
    ) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .rx_bit      (rx_bit),
        .data_take   (data_take),
        .data_bit    (data_bit),
        .flag_evt    (flag_evt),
        .abort_evt   (abort_evt),
        .pre_run_vld (pre_run_vld)
    );

    hdlc_rx_fcs #(
        .FCS_W (FCS_W)
    ) u_fcs (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (data_take),
        .din   (data_bit),
        .init  (flag_evt || abort_evt),
        .match (crc_match)
    );

    hdlc_rx_deframe #(
        .BYTE_W      (BYTE_W),
        .FCS_BYTES   (FCS_BYTES),
        .MIN_PAYLOAD (MIN_PAYLOAD)
    ) u_deframe (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_take   (data_take),
        .data_bit    (data_bit),
        .flag_evt    (flag_evt),
        .abort_evt   (abort_evt),
        .pre_run_vld (pre_run_vld),
        .crc_match   (crc_match),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_last    (out_last),
        .done_valid  (done_valid),
        .done_code   (status)
    );

    assign done_code = status;

endmodule

// File: tb/hdlc_rx_tb.sv
// Self-checking bench: builds stuffed frames with their own check sequence
// and compares the byte stream and status strobes against expectations.
module hdlc_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n, bit_en, rx_bit;
    logic       out_valid, out_last, done_valid;
    logic [7:0] out_data;
    logic [1:0] done_code;

    always #5 clk = ~clk;

    hdlc_rx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .done_valid(done_valid), .done_code(done_code)
    );

    int checks = 0, errors = 0, cyc = 0;
    int cap_n = 0, done_n = 0, done_cyc = 0, lastmis = 0;
    logic [7:0] cap_data  [0:63];
    logic       cap_last  [0:63];
    logic [1:0] done_list [0:7];
    logic [7:0] pay [0:15];
    int ones_tx = 0, gap_mode = 0, bit_idx = 0, last_bit_cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: capture outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && cap_n < 64) begin
                cap_data[cap_n] = out_data;
                cap_last[cap_n] = out_last;
                cap_n++;
            end
            if (out_last && !done_valid) lastmis++;
            if (done_valid) begin
                if (done_n < 8) done_list[done_n] = done_code;
                done_cyc = cyc;
                done_n++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic send_raw(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        rx_bit = b;
        last_bit_cyc = cyc + 1;
        bit_idx++;
        if (gap_mode != 0 && (bit_idx % gap_mode) == 0) begin
            @(negedge clk);
            bit_en = 1'b0;
        end
    endtask

    task automatic send_data_bit(input logic b);
        send_raw(b);
        if (b) begin
            ones_tx++;
            if (ones_tx == 5) begin
                send_raw(1'b0);
                ones_tx = 0;
            end
        end else begin
            ones_tx = 0;
        end
    endtask

    task automatic send_flag();
        for (int i = 0; i < 8; i++) send_raw(i != 0 && i != 7);
        ones_tx = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_data_bit(v[i]);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bit_en = 1'b0;
        end
    endtask

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] v);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++)
            r = (r >> 1) ^ ((r[0] ^ v[i]) ? 16'h8408 : 16'h0000);
        return r;
    endfunction

    // Payload, then the complemented check value low byte first.
    task automatic send_body(input int len, input bit corrupt);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < len; i++) c = crc_byte(c, pay[i]);
        c = ~c;
        if (corrupt) pay[0] = pay[0] ^ 8'h01;
        for (int i = 0; i < len; i++) send_byte(pay[i]);
        send_byte(c[7:0]);
        send_byte(c[15:8]);
    endtask

    task automatic clear_cap();
        cap_n = 0; done_n = 0; lastmis = 0;
    endtask

    task automatic expect_frame(input int len, input int code, input string dtag);
        int bad = 0, lbad = 0;
        idle(5);
        chk("R7 status count", done_n, 1);
        chk("R5 status code", int'(done_list[0]), code);
        chk("R4 payload byte count", cap_n, len);
        for (int i = 0; i < len && i < cap_n; i++) begin
            if (cap_data[i] !== pay[i]) bad++;
            if (cap_last[i] !== (i == len - 1)) lbad++;
        end
        chk(dtag, bad, 0);
        chk("R4 last marker", lbad + lastmis, 0);
    endtask

    task automatic fill(input int pat, input int len);
        for (int i = 0; i < len; i++) begin
            case (pat)
                0: pay[i] = 8'(i * 37 + len);
                1: pay[i] = 8'hFF;
                default: pay[i] = (i % 2) ? 8'h7E : 8'(8'hF8 ^ i);
            endcase
        end
    endtask

    initial begin
        int fc;
        rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 out_valid in reset", int'(out_valid), 0);
        chk("R10 done_valid in reset", int'(done_valid), 0);
        rst_n = 1'b1;
        idle(3);
        chk("R10 out_valid after reset", int'(out_valid), 0);
        chk("R10 done_valid after reset", int'(done_valid), 0);

        // R1: line noise before the first flag is ignored.
        clear_cap();
        for (int i = 0; i < 20; i++) send_raw(i % 3 == 0);
        fill(0, 3);
        send_flag(); send_body(3, 0); send_flag();
        expect_frame(3, 0, "R1 data after preamble");

        // Sweep of lengths, patterns and strobe spacing (R2 R3 R4 R5 R9).
        for (int pat = 0; pat < 3; pat++) begin
            for (int len = 2; len <= 10; len++) begin
                gap_mode = len % 3;
                fill(pat, len);
                clear_cap();
                send_flag(); send_body(len, 0); send_flag();
                fc = last_bit_cyc;
                expect_frame(len, 0, pat == 1 ? "R2 stuffed data" :
                                     pat == 2 ? "R1 flag byte in payload" : "R3 byte data");
                if (len == 5) chk("R9 done latency", done_cyc, fc + 1);
            end
        end
        gap_mode = 0;

        // R5: corrupted payload reports a bad check but still delivers bytes.
        fill(0, 4);
        clear_cap();
        send_flag(); send_body(4, 1); send_flag();
        expect_frame(4, 1, "R5 data of bad frame");

        // R6: abort inside a frame.
        clear_cap();
        send_flag();
        send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
        for (int i = 0; i < 8; i++) send_raw(1'b1);
        fc = last_bit_cyc - 1;
        idle(5);
        chk("R6 abort status count", done_n, 1);
        chk("R6 abort code", int'(done_list[0]), 2);
        chk("R6 no last on abort", lastmis + ((cap_n > 0 && cap_last[cap_n-1]) ? 1 : 0), 0);
        chk("R9 abort latency", done_cyc, fc + 1);
        fill(2, 3);
        clear_cap();
        send_flag(); send_body(3, 0); send_flag();
        expect_frame(3, 0, "R6 recovery data");

        // R6: idle ones after a flag report nothing.
        clear_cap();
        send_flag();
        for (int i = 0; i < 12; i++) send_raw(1'b1);
        send_flag();
        idle(5);
        chk("R6 idle ones status count", done_n, 0);

        // R7: repeated flags give no empty frame.
        clear_cap();
        send_flag(); send_flag(); send_flag();
        idle(5);
        chk("R7 repeated flags status", done_n, 0);
        chk("R7 repeated flags bytes", cap_n, 0);

        // R7: one flag closes a frame and opens the next.
        fill(0, 3);
        clear_cap();
        send_flag(); send_body(3, 0); send_flag(); send_body(3, 0); send_flag();
        idle(5);
        chk("R7 shared flag status count", done_n, 2);
        chk("R7 shared flag codes", int'(done_list[0]) + int'(done_list[1]), 0);
        chk("R7 shared flag bytes", cap_n, 6);

        // R8: one payload byte is too short.
        fill(0, 1);
        clear_cap();
        send_flag(); send_body(1, 0); send_flag();
        idle(5);
        chk("R8 short frame status count", done_n, 1);
        chk("R8 short frame code", int'(done_list[0]), 3);
        chk("R8 short frame bytes", cap_n, 0);

        // R8: bit count not a multiple of eight.
        fill(0, 3);
        clear_cap();
        send_flag(); send_body(3, 0);
        send_data_bit(1'b0); send_data_bit(1'b1); send_data_bit(1'b0);
        send_flag();
        idle(5);
        chk("R8 unaligned code", int'(done_list[0]), 3);
        chk("R8 unaligned no last", lastmis + ((cap_n > 0 && cap_last[cap_n-1]) ? 1 : 0), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule